// File: doc/BRIEF.md
# Four-Core Local Interrupt Router

This block sits beside a four-core cluster and decides which core hears which interrupt source. Every core has four private timer request levels, four mailbox-pending levels and a PMU level, and the cluster shares one GPU interrupt line. For each core the router drives one normal interrupt output (IRQ) and one fast interrupt output (FIQ). Software sets up the routing through a small 32-bit register bus. Each core can read a pending word that shows which of its sources are active at that moment and enabled toward it.

Timer and mailbox sources are enabled per core in one configuration register per core. Each source has a separate IRQ enable and FIQ enable in that register. PMU enables live in one shared field that is changed only by write-one-to-set and write-one-to-clear accesses, so two agents can change their own bits without a read-modify-write. The GPU line goes to exactly one core and one output kind, chosen in a routing register. The interrupt outputs are registered, so a change at an input shows up at the output one clock later.

Top module: `lirq_router`

## Requirements
- R1: After reset every configuration register reads zero, every pending word reads zero while all inputs are low, and all IRQ and FIQ outputs are low.
- R2: The control word (offset 0x00) and the prescaler word (offset 0x08) are plain 32-bit read/write storage. Writing 0x80000000 to the prescaler reads back unchanged.
- R3: The timer configuration word of core n (offset 0x40+4n) uses bit t as the IRQ enable of timer t and bit t+4 as the FIQ enable, for t = 0..3. Only bits [7:0] are stored and the other bits read zero. Timer input t of core n is bit 4n+t of `timer_lvl`.
- R4: The mailbox configuration word of core n (offset 0x50+4n) uses the same layout for mailbox m: bit m enables IRQ and bit m+4 enables FIQ. Mailbox input m of core n is bit 4n+m of `mbox_lvl`.
- R5: A write to offset 0x10 sets every PMU enable bit where the write data holds a 1. A write to offset 0x14 clears every PMU enable bit where the write data holds a 1. Zero bits leave the enables unchanged. Bit n is the PMU IRQ enable of core n and bit n+4 is the PMU FIQ enable of core n. Both offsets read back the current 8-bit enable field.
- R6: The GPU routing word (offset 0x0C) holds the IRQ destination core in bits [1:0], the FIQ destination core in bits [3:2] and an FIQ select flag in bit 4. With the flag clear, the GPU line drives the IRQ of the bits [1:0] core. With the flag set, it drives the FIQ of the bits [3:2] core. Reset value 0 sends the GPU line to the IRQ of core 0. At most one core ever sees the GPU line.
- R7: The read-only pending word of core n (offset 0x60+4n) has these bits: bits [3:0] timers 0–3, bits [7:4] mailboxes 0–3, bit 8 GPU, bit 9 PMU, and zero in bit 10, bit 11 and above. A bit shows the live input level only while that source is enabled toward core n for IRQ or FIQ, and it reads zero otherwise.
- R8: The IRQ output of core n is the OR of its pending sources enabled for IRQ. The FIQ output is the OR of its pending sources enabled for FIQ. Each output follows its inputs and configuration with one clock of latency.
- R9: Reads from unmapped or unaligned offsets return zero. Writes to them, and writes to pending words, change no register.
- R10: Read data appears on `bus_rdata` in the clock cycle after the cycle in which `bus_re` is sampled high, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| timer_lvl | input | 4*NCORES | Timer request levels, four per core |
| mbox_lvl | input | 4*NCORES | Mailbox pending levels, four per core |
| gpu_lvl | input | 1 | Shared GPU interrupt level |
| pmu_lvl | input | NCORES | Per-core PMU interrupt level |
| core_irq | output | NCORES | IRQ output per core |
| core_fiq | output | NCORES | FIQ output per core |

## Verification
The main hazard is a configuration write and a source level change that land in the same clock cycle. A single bus write then has to meet the combinational pending logic and the output flop on one edge. The bench drives a timer-configuration write and the matching timer level on the same falling edge. It checks that the output stays low one edge later and goes high the edge after. It then drops the level while it writes a different enable in the same cycle, and checks that neither output fires. A second overlap is a pending read that samples in the same cycle as a routing change. This is judged against the one-cycle read latency of R10.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

   localparam int GRP_SRCS = 4;
   localparam int CFG_W    = 8;
   localparam int PEND_W   = 12;

   localparam int PB_TIMER = 0;
   localparam int PB_MBOX  = 4;
   localparam int PB_GPU   = 8;
   localparam int PB_PMU   = 9;

   localparam logic [7:0] OFF_CTRL  = 8'h00;
   localparam logic [7:0] OFF_PRE   = 8'h08;
   localparam logic [7:0] OFF_GPU   = 8'h0C;
   localparam logic [7:0] OFF_PSET  = 8'h10;
   localparam logic [7:0] OFF_PCLR  = 8'h14;
   localparam logic [7:0] OFF_TCFG0 = 8'h40;
   localparam logic [7:0] OFF_MCFG0 = 8'h50;
   localparam logic [7:0] OFF_PEND0 = 8'h60;

   typedef struct packed {
      logic       fiq_sel;
      logic [1:0] fiq_core;
      logic [1:0] irq_core;
   } gpu_route_t;

   function automatic logic [7:0] per_core_off(logic [7:0] base, int core);
      return base + 8'(4 * core);
   endfunction

   function automatic logic [CFG_W-1:0] pmu_valid_mask(int ncores);
      logic [CFG_W-1:0] m;
      m = '0;
      for (int i = 0; i < ncores; i++) begin
         m[i]            = 1'b1;
         m[i + GRP_SRCS] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/lirq_regs.sv
module lirq_regs
   import lirq_pkg::*;
#(
   parameter int NCORES = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               bus_we,
   input  logic                               bus_re,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic [DATA_W-1:0]                  bus_wdata,
   input  logic [NCORES-1:0][PEND_W-1:0]      pend_all,
   output logic [DATA_W-1:0]                  bus_rdata,
   output logic [NCORES-1:0][CFG_W-1:0]       tcfg,
   output logic [NCORES-1:0][CFG_W-1:0]       mcfg,
   output logic [CFG_W-1:0]                   pmu_en,
   output gpu_route_t                         gpu_rt
);

   localparam logic [CFG_W-1:0] PMU_MASK = pmu_valid_mask(NCORES);
   localparam int               GW       = $bits(gpu_route_t);

   logic              sel_ctrl, sel_pre, sel_gpu, sel_pset, sel_pclr;
   logic [NCORES-1:0] sel_tcfg, sel_mcfg, sel_pend;
   logic              hit;

   logic [DATA_W-1:0] ctrl_q, pre_q, rd_nxt, rdata_q;
   logic [CFG_W-1:0]  pmu_q;
   gpu_route_t        gpu_q;

   // ---------------- address decode ----------------
   assign sel_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
   assign sel_pre  = (bus_addr == ADDR_W'(OFF_PRE));
   assign sel_gpu  = (bus_addr == ADDR_W'(OFF_GPU));
   assign sel_pset = (bus_addr == ADDR_W'(OFF_PSET));
   assign sel_pclr = (bus_addr == ADDR_W'(OFF_PCLR));

   for (genvar c = 0; c < NCORES; c++) begin : g_dec
      assign sel_tcfg[c] = (bus_addr == ADDR_W'(per_core_off(OFF_TCFG0, c)));
      assign sel_mcfg[c] = (bus_addr == ADDR_W'(per_core_off(OFF_MCFG0, c)));
      assign sel_pend[c] = (bus_addr == ADDR_W'(per_core_off(OFF_PEND0, c)));
   end

   assign hit = sel_ctrl | sel_pre | sel_gpu | sel_pset | sel_pclr
              | (|sel_tcfg) | (|sel_mcfg) | (|sel_pend);

   // ---------------- storage ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         pre_q  <= '0;
         gpu_q  <= '0;
      end else if (bus_we) begin
         if (sel_ctrl) ctrl_q <= bus_wdata;
         if (sel_pre)  pre_q  <= bus_wdata;
         if (sel_gpu)  gpu_q  <= gpu_route_t'(bus_wdata[GW-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pmu_q <= '0;
      else if (bus_we && sel_pset)
         pmu_q <= pmu_q | (bus_wdata[CFG_W-1:0] & PMU_MASK);
      else if (bus_we && sel_pclr)
         pmu_q <= pmu_q & ~bus_wdata[CFG_W-1:0];
   end

   for (genvar c = 0; c < NCORES; c++) begin : g_cfg
      logic [CFG_W-1:0] tcfg_q, mcfg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tcfg_q <= '0;
            mcfg_q <= '0;
         end else if (bus_we) begin
            if (sel_tcfg[c]) tcfg_q <= bus_wdata[CFG_W-1:0];
            if (sel_mcfg[c]) mcfg_q <= bus_wdata[CFG_W-1:0];
         end
      end
      assign tcfg[c] = tcfg_q;
      assign mcfg[c] = mcfg_q;
   end

   // ---------------- read path ----------------
   always_comb begin
      rd_nxt = '0;
      if (sel_ctrl) rd_nxt = ctrl_q;
      if (sel_pre)  rd_nxt = pre_q;
      if (sel_gpu)  rd_nxt = DATA_W'(gpu_q);
      if (sel_pset || sel_pclr) rd_nxt = DATA_W'(pmu_q);
      for (int c = 0; c < NCORES; c++) begin
         if (sel_tcfg[c]) rd_nxt = DATA_W'(tcfg[c]);
         if (sel_mcfg[c]) rd_nxt = DATA_W'(mcfg[c]);
         if (sel_pend[c]) rd_nxt = DATA_W'(pend_all[c]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_re) rdata_q <= rd_nxt;
   end

   assign bus_rdata = rdata_q;
   assign pmu_en    = pmu_q;
   assign gpu_rt    = gpu_q;

   // ---------------- assertions ----------------
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !hit) |=> (bus_rdata == '0));                          // R9
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_re) |=> $stable(bus_rdata));                                // R10
   AST_PMU_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel_pset) |=>
      ((pmu_q & $past(bus_wdata[CFG_W-1:0] & PMU_MASK))
         == $past(bus_wdata[CFG_W-1:0] & PMU_MASK)));                   // R5
   AST_PMU_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel_pclr) |=> ((pmu_q & $past(bus_wdata[CFG_W-1:0])) == '0)); // R5
   AST_PMU_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && (sel_pset || sel_pclr)) |=> $stable(pmu_q));          // R5

endmodule

// File: rtl/lirq_core_route.sv
module lirq_core_route
   import lirq_pkg::*;
#(
   parameter int CORE_ID = 0,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [GRP_SRCS-1:0]  timer_lvl,
   input  logic [GRP_SRCS-1:0]  mbox_lvl,
   input  logic                 gpu_lvl,
   input  logic                 pmu_lvl,
   input  logic [CFG_W-1:0]     tcfg,
   input  logic [CFG_W-1:0]     mcfg,
   input  logic                 pmu_irq_en,
   input  logic                 pmu_fiq_en,
   input  gpu_route_t           gpu_rt,
   output logic [PEND_W-1:0]    pend,
   output logic                 irq_o,
   output logic                 fiq_o
);

   logic              gpu_to_irq, gpu_to_fiq;
   logic [PEND_W-1:0] irq_mask, fiq_mask;
   logic              irq_d, fiq_d;

   assign gpu_to_irq = !gpu_rt.fiq_sel && (gpu_rt.irq_core == 2'(CORE_ID));
   assign gpu_to_fiq =  gpu_rt.fiq_sel && (gpu_rt.fiq_core == 2'(CORE_ID));

   always_comb begin
      irq_mask = '0;
      fiq_mask = '0;
      irq_mask[PB_TIMER +: GRP_SRCS] = tcfg[GRP_SRCS-1:0];
      fiq_mask[PB_TIMER +: GRP_SRCS] = tcfg[CFG_W-1:GRP_SRCS];
      irq_mask[PB_MBOX  +: GRP_SRCS] = mcfg[GRP_SRCS-1:0];
      fiq_mask[PB_MBOX  +: GRP_SRCS] = mcfg[CFG_W-1:GRP_SRCS];
      irq_mask[PB_GPU]               = gpu_to_irq;
      fiq_mask[PB_GPU]               = gpu_to_fiq;
      irq_mask[PB_PMU]               = pmu_irq_en;
      fiq_mask[PB_PMU]               = pmu_fiq_en;
   end

   always_comb begin
      pend = '0;
      pend[PB_TIMER +: GRP_SRCS] = timer_lvl;
      pend[PB_MBOX  +: GRP_SRCS] = mbox_lvl;
      pend[PB_GPU]               = gpu_lvl;
      pend[PB_PMU]               = pmu_lvl;
      pend = pend & (irq_mask | fiq_mask);
   end

   assign irq_d = |(pend & irq_mask);
   assign fiq_d = |(pend & fiq_mask);

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
         end else begin
            irq_o <= irq_d;
            fiq_o <= fiq_d;
         end
      end

      AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (pend == '0) |=> (!irq_o && !fiq_o));                          // R8
      AST_TIMER_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         (|(timer_lvl & tcfg[GRP_SRCS-1:0])) |=> irq_o);                // R3
      AST_MBOX_FIQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         (|(mbox_lvl & mcfg[CFG_W-1:GRP_SRCS])) |=> fiq_o);             // R4
   end else begin : g_comb_out
      assign irq_o = irq_d;
      assign fiq_o = fiq_d;
   end

endmodule

// File: rtl/lirq_router.sv
module lirq_router
   import lirq_pkg::*;
#(
   parameter int NCORES  = 4,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_we,
   input  logic                       bus_re,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [DATA_W-1:0]          bus_rdata,
   input  logic [GRP_SRCS*NCORES-1:0] timer_lvl,
   input  logic [GRP_SRCS*NCORES-1:0] mbox_lvl,
   input  logic                       gpu_lvl,
   input  logic [NCORES-1:0]          pmu_lvl,
   output logic [NCORES-1:0]          core_irq,
   output logic [NCORES-1:0]          core_fiq
);

   if (NCORES < 1 || NCORES > 4) begin : g_bad_ncores
      $error("lirq_router: NCORES must lie in 1..4");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("lirq_router: ADDR_W must be at least 8");
   end
   if (DATA_W < PEND_W) begin : g_bad_data
      $error("lirq_router: DATA_W too narrow for pending word");
   end

   logic [NCORES-1:0][PEND_W-1:0] pend_all;
   logic [NCORES-1:0][CFG_W-1:0]  tcfg, mcfg;
   logic [CFG_W-1:0]              pmu_en;
   gpu_route_t                    gpu_rt;
   logic [NCORES-1:0]             gpu_seen;

   lirq_regs #(
      .NCORES (NCORES),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pend_all  (pend_all),
      .bus_rdata (bus_rdata),
      .tcfg      (tcfg),
      .mcfg      (mcfg),
      .pmu_en    (pmu_en),
      .gpu_rt    (gpu_rt)
   );

   for (genvar c = 0; c < NCORES; c++) begin : g_core
      lirq_core_route #(
         .CORE_ID (c),
         .REG_OUT (REG_OUT)
      ) u_route (
         .clk        (clk),
         .rst_n      (rst_n),
         .timer_lvl  (timer_lvl[c*GRP_SRCS +: GRP_SRCS]),
         .mbox_lvl   (mbox_lvl[c*GRP_SRCS +: GRP_SRCS]),
         .gpu_lvl    (gpu_lvl),
         .pmu_lvl    (pmu_lvl[c]),
         .tcfg       (tcfg[c]),
         .mcfg       (mcfg[c]),
         .pmu_irq_en (pmu_en[c]),
         .pmu_fiq_en (pmu_en[c + GRP_SRCS]),
         .gpu_rt     (gpu_rt),
         .pend       (pend_all[c]),
         .irq_o      (core_irq[c]),
         .fiq_o      (core_fiq[c])
      );
      assign gpu_seen[c] = pend_all[c][PB_GPU];
   end

   AST_GPU_SINGLE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gpu_seen));                                              // R6
   AST_GPU_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (!gpu_lvl) |-> (gpu_seen == '0));                                 // R7

endmodule

// File: tb/sim_lirq_router.sv
`timescale 1ns/1ps
module sim_lirq_router;

   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] timer_lvl = '0;
   logic [15:0] mbox_lvl = '0;
   logic        gpu_lvl = 1'b0;
   logic [3:0]  pmu_lvl = '0;
   logic [3:0]  core_irq, core_fiq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lirq_router #(.NCORES(NC)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .timer_lvl(timer_lvl), .mbox_lvl(mbox_lvl), .gpu_lvl(gpu_lvl),
      .pmu_lvl(pmu_lvl), .core_irq(core_irq), .core_fiq(core_fiq)
   );

   function automatic logic [7:0] a_tcfg(int c); return 8'h40 + 8'(4*c); endfunction
   function automatic logic [7:0] a_mcfg(int c); return 8'h50 + 8'(4*c); endfunction
   function automatic logic [7:0] a_pend(int c); return 8'h60 + 8'(4*c); endfunction

   task automatic chk(logic [31:0] act, logic [31:0] exp, string req, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_re = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_re = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle();
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic cleanup();
      timer_lvl = '0; mbox_lvl = '0; gpu_lvl = 1'b0; pmu_lvl = '0;
      for (int c = 0; c < NC; c++) begin
         wr(a_tcfg(c), 32'h0);
         wr(a_mcfg(c), 32'h0);
      end
      wr(8'h14, 32'hFF);
      wr(8'h0C, 32'h0);
      settle();
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk(32'(core_irq), 32'h0, "R1", "irq after reset");
      chk(32'(core_fiq), 32'h0, "R1", "fiq after reset");
      rd(8'h00, d); chk(d, 32'h0, "R1", "control reset");
      rd(8'h0C, d); chk(d, 32'h0, "R1", "gpu route reset");
      rd(8'h10, d); chk(d, 32'h0, "R1", "pmu enables reset");
      rd(a_tcfg(3), d); chk(d, 32'h0, "R1", "timer cfg 3 reset");
      rd(a_pend(0), d); chk(d, 32'h0, "R1", "pending 0 reset");
   endtask

   task automatic t_plain_regs();
      logic [31:0] d;
      wr(8'h08, 32'h8000_0000);
      rd(8'h08, d); chk(d, 32'h8000_0000, "R2", "prescaler readback");
      wr(8'h00, 32'hA5C3_1E07);
      rd(8'h00, d); chk(d, 32'hA5C3_1E07, "R2", "control readback");
      rd(8'h08, d); chk(d, 32'h8000_0000, "R2", "prescaler kept");
   endtask

   task automatic t_timer();
      logic [31:0] d;
      wr(a_tcfg(1), 32'hFFFF_FF04);
      rd(a_tcfg(1), d); chk(d, 32'h04, "R3", "timer cfg upper bits dropped");
      timer_lvl[1*4+2] = 1'b1;
      timer_lvl[0]     = 1'b1;            // core 0 timer 0 not enabled
      settle();
      chk(32'(core_irq), 32'h2, "R3", "timer2 IRQ on core1");
      chk(32'(core_fiq), 32'h0, "R3", "no fiq");
      rd(a_pend(1), d); chk(d, 32'h004, "R7", "pending core1");
      rd(a_pend(0), d); chk(d, 32'h000, "R7", "unenabled timer hidden");
      wr(a_tcfg(1), 32'h40);
      settle();
      chk(32'(core_irq), 32'h0, "R3", "irq off after fiq select");
      chk(32'(core_fiq), 32'h2, "R3", "timer2 FIQ on core1");
      cleanup();
   endtask

   task automatic t_mbox();
      logic [31:0] d;
      wr(a_mcfg(3), 32'h81);
      mbox_lvl[3*4+0] = 1'b1;
      mbox_lvl[3*4+3] = 1'b1;
      mbox_lvl[2*4+0] = 1'b1;             // core 2 not enabled
      settle();
      chk(32'(core_irq), 32'h8, "R4", "mbox0 IRQ core3");
      chk(32'(core_fiq), 32'h8, "R4", "mbox3 FIQ core3");
      rd(a_pend(3), d); chk(d, 32'h090, "R7", "pending core3 mailboxes");
      rd(a_pend(2), d); chk(d, 32'h000, "R7", "pending core2 hidden");
      cleanup();
   endtask

   task automatic t_pmu();
      logic [31:0] d;
      wr(8'h10, 32'h21);
      pmu_lvl = 4'hF;
      settle();
      chk(32'(core_irq), 32'h1, "R5", "pmu irq core0");
      chk(32'(core_fiq), 32'h2, "R5", "pmu fiq core1");
      rd(a_pend(1), d); chk(d, 32'h200, "R7", "pmu pending core1");
      rd(a_pend(2), d); chk(d, 32'h000, "R7", "pmu hidden core2");
      wr(8'h14, 32'h01);
      rd(8'h10, d); chk(d, 32'h20, "R5", "clear bit0 only");
      wr(8'h10, 32'h00);
      rd(8'h14, d); chk(d, 32'h20, "R5", "zero set leaves bits");
      settle();
      chk(32'(core_irq), 32'h0, "R5", "irq after clear");
      chk(32'(core_fiq), 32'h2, "R5", "fiq kept after clear");
      cleanup();
   endtask

   task automatic t_gpu();
      logic [31:0] d;
      gpu_lvl = 1'b1;
      settle();
      chk(32'(core_irq), 32'h1, "R6", "gpu default to core0 irq");
      rd(a_pend(0), d); chk(d, 32'h100, "R7", "gpu pending core0");
      wr(8'h0C, 32'h02);
      settle();
      chk(32'(core_irq), 32'h4, "R6", "gpu to core2 irq");
      wr(8'h0C, 32'h1C);
      settle();
      chk(32'(core_irq), 32'h0, "R6", "no irq in fiq mode");
      chk(32'(core_fiq), 32'h8, "R6", "gpu to core3 fiq");
      rd(a_pend(3), d); chk(d, 32'h100, "R6", "gpu pending core3");
      rd(a_pend(0), d); chk(d, 32'h000, "R6", "gpu absent core0");
      cleanup();
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a_tcfg(2); bus_wdata = 32'h01;
      timer_lvl[2*4+0] = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
      chk(32'(core_irq), 32'h0, "R8", "output not yet updated");
      @(posedge clk); #1;
      chk(32'(core_irq), 32'h4, "R8", "output one cycle after cfg+level");
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a_tcfg(2); bus_wdata = 32'h10;
      timer_lvl[2*4+0] = 1'b0;
      @(posedge clk); #1;
      bus_we = 1'b0;
      @(posedge clk); #1;
      chk(32'(core_irq), 32'h0, "R8", "irq dropped");
      chk(32'(core_fiq), 32'h0, "R8", "fiq not raised with level low");
      cleanup();
   endtask

   task automatic t_read_latency();
      @(negedge clk);
      bus_re = 1'b1; bus_addr = 8'h08;
      @(posedge clk); #1;
      bus_re = 1'b0;
      chk(bus_rdata, 32'h8000_0000, "R10", "data one edge after strobe");
      bus_addr = 8'h00;
      @(posedge clk); #1;
      chk(bus_rdata, 32'h8000_0000, "R10", "data held without strobe");
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h70, 32'hFFFF_FFFF);
      wr(a_pend(0), 32'hFFFF_FFFF);
      rd(8'h04, d); chk(d, 32'h0, "R9", "unmapped 0x04");
      rd(8'h70, d); chk(d, 32'h0, "R9", "unmapped 0x70");
      rd(8'h41, d); chk(d, 32'h0, "R9", "unaligned 0x41");
      rd(8'h00, d); chk(d, 32'hA5C3_1E07, "R9", "control untouched");
      rd(8'h10, d); chk(d, 32'h0, "R9", "pmu untouched");
      rd(a_tcfg(0), d); chk(d, 32'h0, "R9", "timer cfg untouched");
      rd(a_pend(0), d); chk(d, 32'h0, "R9", "pending write ignored");
      timer_lvl = 16'hFFFF;
      settle();
      chk(32'(core_irq), 32'h0, "R9", "no enable created");
      timer_lvl = '0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_plain_regs();
      t_timer();
      t_mbox();
      t_pmu();
      t_gpu();
      t_same_cycle();
      t_read_latency();
      t_unmapped();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule